// File: doc/BRIEF.md
# Remote Alarm Persistence Qualifier

This block watches two received overhead bits once per frame: the remote alarm bit and the far-end error bit. The alarm pattern is the alarm bit at 1 and the error bit at 0. A persistence timer counts the consecutive frame ticks on which the pattern is present. The timer is compared against two windows.

A live indication is high for as long as the pattern has lasted past the short window. A sticky flag records a run that lasted past the short window and then ended before the long window. A run that lasts past the long window is taken to be a steady alarm and does not set the flag. Software reads both bits from an 8-bit status word. A read strobe clears the sticky flag. Extracting the two bits from the frame happens upstream of this block.

The defaults assume 125 µs frame ticks. With that tick, 80 ticks make 10 ms and 3600 ticks make 450 ms. Both window lengths are parameters.

Top module: `alarm_run_qualifier`

## Requirements
- R1: The pattern is sampled only on cycles where `tick_i` is 1. It is true when `a_bit_i`=1 and `e_bit_i`=0. Changes to the inputs between ticks have no effect on either status bit.
- R2: `status_o[0]` (the live bit) is 0 after 80 consecutive pattern ticks. It becomes 1 on the clock edge of the 81st consecutive pattern tick.
- R3: A tick on which the pattern is false clears the run timer, and `status_o[0]` reads 0 after that edge.
- R4: `status_o[1]` (the sticky bit) is set on the edge of the tick that ends a run of 81 to 3599 consecutive pattern ticks. It then holds until it is read.
- R5: A run of 80 ticks or fewer, or of 3600 ticks or more, does not set `status_o[1]` when it ends.
- R6: A clock edge with `rd_i`=1 clears `status_o[1]`. When a set event from R4 falls on that same edge, the bit stays 1.
- R7: `status_o[7:2]` always read 0.
- R8: After reset, `status_o` is 8'h00.
- R9: The run timer saturates instead of wrapping. After 5000 pattern ticks `status_o[0]` is still 1, and ending that run leaves `status_o[1]` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Frame tick strobe, one cycle wide |
| a_bit_i | input | 1 | Received remote alarm bit |
| e_bit_i | input | 1 | Received far-end error bit |
| rd_i | input | 1 | Status read strobe; clears the sticky bit |
| status_o | output | 8 | Status word: bit 0 is the live bit, bit 1 is the sticky bit, the other bits are 0 |

## Verification
Every result is due exactly one clock edge after its stimulus. A tick updates the timer and the live bit on its own edge. The tick that ends a run sets the sticky bit on that same edge, and a read clears it on the edge where `rd_i` is high. The bench drives each tick or read for one cycle starting at a falling edge. It samples `status_o` at the next falling edge, which comes after the single rising edge that carries the update, so no check depends on the order of processes at an edge. The run lengths in the table sit on both sides of each window boundary.

// File: rtl/alarm_run_pkg.sv
package alarm_run_pkg;
   localparam int unsigned STAT_BIT_LIVE   = 0;
   localparam int unsigned STAT_BIT_STICKY = 1;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/alarm_run_timer.sv
module alarm_run_timer #(
   parameter int unsigned LIMIT = 3600,
   parameter int unsigned W     = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         cond,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CAP = W'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (tick) begin
         if (!cond)
            cnt <= '0;
         else if (cnt != CAP)
            cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/alarm_window_eval.sv
module alarm_window_eval #(
   parameter int unsigned SHORT_TICKS = 80,
   parameter int unsigned LONG_TICKS  = 3600,
   parameter int unsigned W           = 12
) (
   input  logic [W-1:0] cnt,
   input  logic         tick,
   input  logic         cond,
   output logic         live,
   output logic         run_hit
);
   localparam logic [W-1:0] LO = W'(SHORT_TICKS);
   localparam logic [W-1:0] HI = W'(LONG_TICKS);

   always_comb begin
      live    = (cnt > LO);
      run_hit = tick && !cond && (cnt > LO) && (cnt < HI);
   end
endmodule

// File: rtl/alarm_sticky_bit.sv
module alarm_sticky_bit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb nxt = set ? 1'b1 : (clr ? 1'b0 : q);
      end else begin : g_clr_first
         always_comb nxt = clr ? 1'b0 : (set ? 1'b1 : q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end
endmodule

// File: rtl/alarm_run_qualifier.sv
module alarm_run_qualifier #(
   parameter int unsigned SHORT_TICKS = 80,
   parameter int unsigned LONG_TICKS  = 3600,
   parameter int unsigned STAT_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              a_bit_i,
   input  logic              e_bit_i,
   input  logic              rd_i,
   output logic [STAT_W-1:0] status_o
);
   import alarm_run_pkg::*;

   localparam int unsigned TW = cnt_width(LONG_TICKS);

   generate
      if (SHORT_TICKS >= LONG_TICKS) begin : g_bad_window
         $error("SHORT_TICKS must be below LONG_TICKS");
      end
      if (STAT_W < 2) begin : g_bad_width
         $error("STAT_W must hold two status bits");
      end
   endgenerate

   logic          pattern;
   logic [TW-1:0] run_cnt;
   logic          live;
   logic          run_hit;
   logic          sticky;

   assign pattern = a_bit_i & ~e_bit_i;

   alarm_run_timer #(.LIMIT(LONG_TICKS), .W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .cond(pattern), .cnt(run_cnt)
   );

   alarm_window_eval #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS), .W(TW)) u_win (
      .cnt(run_cnt), .tick(tick_i), .cond(pattern), .live(live), .run_hit(run_hit)
   );

   alarm_sticky_bit #(.SET_WINS(1'b1)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set(run_hit), .clr(rd_i), .q(sticky)
   );

   generate
      for (genvar b = 0; b < STAT_W; b++) begin : g_stat
         if (b == STAT_BIT_LIVE) begin : g_live
            assign status_o[b] = live;
         end else if (b == STAT_BIT_STICKY) begin : g_stk
            assign status_o[b] = sticky;
         end else begin : g_zero
            assign status_o[b] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/alarm_run_checks.sv
module alarm_run_checks #(
   parameter int unsigned STAT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              a_bit_i,
   input logic              e_bit_i,
   input logic              rd_i,
   input logic [STAT_W-1:0] status_o
);
   assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[STAT_W-1:2] == '0);

   assert_no_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(status_o[0]));

   assert_drop_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !(a_bit_i && !e_bit_i)) |=> !status_o[0]);

   assert_live_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i || !(a_bit_i && !e_bit_i)) |=> !$rose(status_o[0]));

   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !tick_i) |=> !status_o[1]);

   assert_sticky_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && status_o[1]) |=> status_o[1]);

   assert_sticky_set_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_i && !(a_bit_i && !e_bit_i)) |=> !$rose(status_o[1]));
endmodule

bind alarm_run_qualifier alarm_run_checks #(.STAT_W(STAT_W)) u_checks (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .a_bit_i(a_bit_i),
   .e_bit_i(e_bit_i), .rd_i(rd_i), .status_o(status_o)
);

// File: tb/sim_alarm_run_qualifier.sv
module sim_alarm_run_qualifier;
   localparam int CLK_PERIOD = 10;
   localparam int VEC_N = 7;
   localparam int RUN_LEN [VEC_N] = '{10, 80, 81, 200, 3599, 3600, 5000};
   localparam bit EXP_STK [VEC_N] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       a_bit_i = 1'b0;
   logic       e_bit_i = 1'b0;
   logic       rd_i = 1'b0;
   logic [7:0] status_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alarm_run_qualifier u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .a_bit_i(a_bit_i),
      .e_bit_i(e_bit_i), .rd_i(rd_i), .status_o(status_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // one cycle of stimulus driven from a falling edge, result sampled at the next falling edge
   task automatic step(input logic tk, input logic a, input logic e, input logic rd);
      @(negedge clk);
      tick_i = tk; a_bit_i = a; e_bit_i = e; rd_i = rd;
      @(negedge clk);
      tick_i = 1'b0; rd_i = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset state", status_o, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 after release", status_o, 8'h00);

      for (int v = 0; v < VEC_N; v++) begin
         step(1'b1, 1'b0, 1'b0, 1'b1);
         run_ticks(RUN_LEN[v]);
         chk($sformatf("R2 R9 live after %0d ticks", RUN_LEN[v]), status_o & 8'h01,
             (RUN_LEN[v] > 80) ? 8'h01 : 8'h00);
         step(1'b1, 1'b0, 1'b0, 1'b0);
         chk($sformatf("R3 R4 R5 end of run %0d", RUN_LEN[v]), status_o,
             {6'b0, EXP_STK[v], 1'b0});
      end

      // R2 exact boundary, and R7 with the live bit set
      step(1'b1, 1'b0, 1'b0, 1'b1);
      run_ticks(80);
      chk("R2 boundary 80 ticks", status_o, 8'h00);
      run_ticks(1);
      chk("R2 R7 boundary 81 ticks", status_o, 8'h01);

      // R1: a false pattern without a tick is ignored
      step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R1 no tick keeps live", status_o, 8'h01);
      // R1: both bits high is not the pattern
      step(1'b1, 1'b1, 1'b1, 1'b0);
      chk("R1 R3 a=1 e=1 ends run", status_o, 8'h02);

      // R6 read clears, then set and read on the same edge
      step(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R6 read clears sticky", status_o, 8'h00);
      run_ticks(100);
      step(1'b1, 1'b0, 1'b0, 1'b1);
      chk("R6 set wins over read", status_o, 8'h02);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R4 sticky holds without read", status_o, 8'h02);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R6 second read clears", status_o, 8'h00);

      // R8 reset in mid run
      run_ticks(90);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 reset mid run", status_o, 8'h00);
      rst_n = 1'b1;
      run_ticks(80);
      chk("R8 timer restarted", status_o, 8'h00);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule